// File: doc/BRIEF.md
# Transfer Descriptor Completion Checker

This block judges one finished transfer descriptor at a time. Each descriptor carries four status flags, the endpoint direction, an isochronous marker, the byte count still owed by the transfer and the byte count moved by the last packet. The block works out the new remaining count and gives one result code. Callers use that code to decide what to do next: retire the transfer, wait for more packets, accept a short receive, or take an error path.

Descriptors come in on a valid/ready handshake. Results leave through a single registered stage with its own valid/ready handshake. A new descriptor can be taken in every cycle while the consumer keeps its ready signal high. The status flags are passed out alongside each result, so an unclassified failure can be examined later.

Status bit layout on `in_status` and `out_status`: bit 3 active, bit 2 halted, bit 1 transaction error, bit 0 data buffer error. Result codes on `out_result`: 0 success, 1 pending, 2 short receive, 3 overflow, 4 isochronous packet error, 5 isochronous fulfillment error, 6 unclassified failure.

Top module: `td_done_check`

## Requirements
- R1: With all four status bits 0 and a remaining count that reaches 0 after the update, the result is 0 (success).
- R2: When active is 0 and the actual count does not exceed the owed count, the remaining count output equals owed minus actual.
- R3: A transmit descriptor (`in_dir_rx`=0) with all status bits 0 and a nonzero remaining count gives result 1 (pending).
- R4: A receive descriptor (`in_dir_rx`=1) with all status bits 0 and a nonzero remaining count gives result 2 (short receive completion).
- R5: Active=1 gives result 1 (pending) and returns the owed count unchanged, whatever the other inputs are.
- R6: Halted=0, data buffer error=1 and transaction error=0 give result 3 (overflow) for either direction and either endpoint type.
- R7: On an isochronous receive descriptor, halted=0, transaction error=1 and data buffer error=0 give result 4.
- R8: On an isochronous receive descriptor, halted=0, transaction error=1 and data buffer error=1 give result 5.
- R9: Every other status combination gives result 6 (unclassified). `out_status` always carries the descriptor's status bits unchanged.
- R10: With active=0 and actual greater than owed, the result is 3 (overflow) and the remaining count is 0. This takes priority over every status combination other than active.
- R11: A result appears on the outputs in the cycle after its descriptor is accepted. It stays stable while `out_ready` is low, and `in_ready` stays low while an unconsumed result is being held.
- R12: During reset and until the reset is released, `out_valid` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A descriptor is offered |
| in_ready | output | 1 | The block can take a descriptor |
| in_status | input | 4 | Status flags {active, halted, xact_err, buf_err} |
| in_dir_rx | input | 1 | 1 = receive endpoint, 0 = transmit |
| in_iso | input | 1 | 1 = isochronous endpoint |
| in_total | input | BYTE_W | Bytes still owed before this packet |
| in_actual | input | BYTE_W | Bytes moved by this packet |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 3 | Result code |
| out_remaining | output | BYTE_W | Updated remaining byte count |
| out_status | output | 4 | Status flags passed through |

## Verification
Every result is due exactly one clock after the rising edge where `in_valid` and `in_ready` are both high. The bench drives each descriptor on a falling edge and checks the result of the previous descriptor on the next falling edge. This keeps one descriptor in flight per cycle with no ordering race at the active edge. For the stall case, the bench holds `out_ready` low for several cycles and checks on each falling edge that the held result has not changed. It then releases the stall and checks the queued descriptor one cycle after the edge that accepts it.

// File: rtl/td_pkg.sv
package td_pkg;
  // status vector bit positions
  localparam int unsigned ST_ACTIVE = 3;
  localparam int unsigned ST_HALT   = 2;
  localparam int unsigned ST_XERR   = 1;
  localparam int unsigned ST_BERR   = 0;
  localparam int unsigned ST_W      = 4;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_PENDING    = 3'd1,
    RES_SHORT_RX   = 3'd2,
    RES_OVERFLOW   = 3'd3,
    RES_ISO_PKT    = 3'd4,
    RES_ISO_FULFIL = 3'd5,
    RES_UNCLASS    = 3'd6
  } td_result_e;
endpackage

// File: rtl/td_rst_sync.sv
module td_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/td_byte_calc.sv
module td_byte_calc #(
  parameter int unsigned BYTE_W = 16
) (
  input  logic [BYTE_W-1:0] total,
  input  logic [BYTE_W-1:0] actual,
  output logic [BYTE_W-1:0] remaining,
  output logic              over,
  output logic              rem_zero
);
  always_comb begin
    over      = (actual > total);
    remaining = over ? '0 : (total - actual);
    rem_zero  = (remaining == '0);
  end
endmodule

// File: rtl/td_classify.sv
module td_classify
  import td_pkg::*;
(
  input  logic [ST_W-1:0] status,
  input  logic            dir_rx,
  input  logic            iso,
  input  logic            over,
  input  logic            rem_zero,
  output td_result_e      result
);
  logic iso_rx;

  always_comb begin
    iso_rx = iso & dir_rx;
    result = RES_UNCLASS;
    if (status[ST_ACTIVE]) begin
      result = RES_PENDING;
    end else if (over) begin
      result = RES_OVERFLOW;
    end else if (!status[ST_HALT]) begin
      case ({status[ST_XERR], status[ST_BERR]})
        2'b00: begin
          if (rem_zero)    result = RES_OK;
          else if (dir_rx) result = RES_SHORT_RX;
          else             result = RES_PENDING;
        end
        2'b01:   result = RES_OVERFLOW;
        2'b10:   result = iso_rx ? RES_ISO_PKT    : RES_UNCLASS;
        default: result = iso_rx ? RES_ISO_FULFIL : RES_UNCLASS;
      endcase
    end
  end
endmodule

// File: rtl/td_out_stage.sv
module td_out_stage
  import td_pkg::*;
#(
  parameter int unsigned BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_ok,
  input  logic              in_valid,
  output logic              in_ready,
  input  td_result_e        d_result,
  input  logic [BYTE_W-1:0] d_remaining,
  input  logic [ST_W-1:0]   d_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_result,
  output logic [BYTE_W-1:0] out_remaining,
  output logic [ST_W-1:0]   out_status
);
  logic              vld_q, vld_d;
  logic              load_en;
  td_result_e        res_q;
  logic [BYTE_W-1:0] rem_q;
  logic [ST_W-1:0]   st_q;

  always_comb begin
    in_ready = rst_ok & (~vld_q | out_ready);
    load_en  = in_valid & in_ready;
    vld_d    = vld_q;
    if (load_en)        vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // data path: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      res_q <= d_result;
      rem_q <= d_remaining;
      st_q  <= d_status;
    end
  end

  assign out_valid     = vld_q;
  assign out_result    = res_q;
  assign out_remaining = rem_q;
  assign out_status    = st_q;
endmodule

// File: rtl/td_done_check.sv
module td_done_check
  import td_pkg::*;
#(
  parameter int unsigned BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_status,
  input  logic              in_dir_rx,
  input  logic              in_iso,
  input  logic [BYTE_W-1:0] in_total,
  input  logic [BYTE_W-1:0] in_actual,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_result,
  output logic [BYTE_W-1:0] out_remaining,
  output logic [3:0]        out_status
);
  logic              rst_ok;
  logic [BYTE_W-1:0] calc_rem;
  logic [BYTE_W-1:0] new_rem;
  logic              over;
  logic              rem_zero;
  td_result_e        cls_result;

  td_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  td_byte_calc #(.BYTE_W(BYTE_W)) u_calc (
    .total     (in_total),
    .actual    (in_actual),
    .remaining (calc_rem),
    .over      (over),
    .rem_zero  (rem_zero)
  );

  td_classify u_cls (
    .status   (in_status),
    .dir_rx   (in_dir_rx),
    .iso      (in_iso),
    .over     (over),
    .rem_zero (rem_zero),
    .result   (cls_result)
  );

  // a still-active descriptor keeps its owed count
  assign new_rem = in_status[ST_ACTIVE] ? in_total : calc_rem;

  td_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_ok        (rst_ok),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .d_result      (cls_result),
    .d_remaining   (new_rem),
    .d_status      (in_status),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_result    (out_result),
    .out_remaining (out_remaining),
    .out_status    (out_status)
  );
endmodule

// File: rtl/td_done_check_sva.sv
module td_done_check_sva #(
  parameter int unsigned BYTE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_status,
  input logic [BYTE_W-1:0] in_total,
  input logic [BYTE_W-1:0] in_actual,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_result,
  input logic [BYTE_W-1:0] out_remaining,
  input logic [3:0]        out_status
);
  logic fire;
  assign fire = in_valid & in_ready;

  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_remaining) && $stable(out_status));

  p_block_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_load_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid && out_status == $past(in_status));

  p_active_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_status[3] |=> out_result == 3'd1 && out_remaining == $past(in_total));

  p_over_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_status[3] && (in_actual > in_total) |=>
      out_result == 3'd3 && out_remaining == '0);

  p_ok_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_result == 3'd0 |-> out_status == 4'b0000 && out_remaining == '0);

  p_reset_idle_r12: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !in_ready);
endmodule

bind td_done_check td_done_check_sva #(.BYTE_W(BYTE_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_status     (in_status),
  .in_total      (in_total),
  .in_actual     (in_actual),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_result    (out_result),
  .out_remaining (out_remaining),
  .out_status    (out_status)
);

// File: tb/sim_td_done_check.sv
module sim_td_done_check;
  localparam int unsigned BW      = 4;
  localparam time         CLK_PER = 10ns;
  localparam int          WDOG    = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_status = '0;
  logic          in_dir_rx = 1'b0;
  logic          in_iso = 1'b0;
  logic [BW-1:0] in_total = '0;
  logic [BW-1:0] in_actual = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [2:0]    out_result;
  logic [BW-1:0] out_remaining;
  logic [3:0]    out_status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PER/2) clk = ~clk;

  td_done_check #(.BYTE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_status(in_status), .in_dir_rx(in_dir_rx), .in_iso(in_iso),
    .in_total(in_total), .in_actual(in_actual), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result),
    .out_remaining(out_remaining), .out_status(out_status)
  );

  // expected result from the requirement table
  function automatic logic [2:0] model_res(logic [3:0] st, logic rx, logic iso,
                                           int tot, int act);
    int rem;
    if (st[3]) return 3'd1;                      // R5
    if (act > tot) return 3'd3;                  // R10
    rem = tot - act;
    if (st[2]) return 3'd6;                      // R9
    case (st[1:0])
      2'b00:   return (rem == 0) ? 3'd0 : (rx ? 3'd2 : 3'd1); // R1 R3 R4
      2'b01:   return 3'd3;                      // R6
      2'b10:   return (rx && iso) ? 3'd4 : 3'd6; // R7 R9
      default: return (rx && iso) ? 3'd5 : 3'd6; // R8 R9
    endcase
  endfunction

  function automatic int model_rem(logic [3:0] st, int tot, int act);
    if (st[3]) return tot;       // R5
    if (act > tot) return 0;     // R10
    return tot - act;            // R2
  endfunction

  function automatic string tag_of(logic [2:0] r, logic [3:0] st, int tot, int act);
    if (st[3]) return "R5";
    if (act > tot) return "R10";
    case (r)
      3'd0: return "R1/R2";
      3'd1: return "R3/R2";
      3'd2: return "R4/R2";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_out(string tag, logic [2:0] er, int erem, logic [3:0] est);
    checks++;
    if (!out_valid || out_result != er || out_remaining != erem[BW-1:0] ||
        out_status != est) begin
      errors++;
      $display("FAIL %s: got v=%0d res=%0d rem=%0d st=%b, exp v=1 res=%0d rem=%0d st=%b",
               tag, out_valid, out_result, out_remaining, out_status, er, erem, est);
    end
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin : main
    logic [2:0] pr; int prem; logic [3:0] pst; string ptag; logic have;
    // R12: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R12: got v=%b rdy=%b, exp v=0 rdy=0", out_valid, in_ready);
    end
    @(negedge clk) rst_n = 1'b1;
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R12: got rdy=%b right after release, exp 0", in_ready);
    end
    repeat (3) @(negedge clk);

    // exhaustive sweep, one descriptor per cycle, result checked next cycle
    have = 1'b0; pr = '0; prem = 0; pst = '0; ptag = "";
    for (int s = 0; s < 16; s++)
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 2; i++)
          for (int t = 0; t < (1 << BW); t++)
            for (int a = 0; a < (1 << BW); a++) begin
              if (have) check_out(ptag, pr, prem, pst);
              in_valid  = 1'b1;
              in_status = s[3:0];
              in_dir_rx = d[0];
              in_iso    = i[0];
              in_total  = t[BW-1:0];
              in_actual = a[BW-1:0];
              pr   = model_res(s[3:0], d[0], i[0], t, a);
              prem = model_rem(s[3:0], t, a);
              pst  = s[3:0];
              ptag = tag_of(pr, s[3:0], t, a);
              have = 1'b1;
              @(negedge clk);
            end
    check_out(ptag, pr, prem, pst);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: got v=%b after drain, exp 0", out_valid);
    end

    // R11: stall holds result and blocks input
    out_ready = 1'b0;
    in_valid = 1'b1; in_status = 4'b0001; in_dir_rx = 1'b0; in_iso = 1'b0;
    in_total = 4'd9; in_actual = 4'd2;
    @(negedge clk);
    in_status = 4'b0000; in_dir_rx = 1'b1; in_total = 4'd7; in_actual = 4'd3;
    for (int k = 0; k < 3; k++) begin
      check_out("R11 hold", 3'd3, 7, 4'b0001);
      checks++;
      if (in_ready !== 1'b0) begin
        errors++;
        $display("FAIL R11: got rdy=%b while stalled, exp 0", in_ready);
      end
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_out("R11 release R4", 3'd2, 4, 4'b0000);
    in_valid = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule